// File: doc/BRIEF.md
# Integer ALU with Packed Condition Flags

A purely combinational 32-bit integer arithmetic and logic unit with a barrel shifter, meant for the execute stage of a small 32-bit load/store core. It takes two operands that have already been chosen outside the block, a 5-bit operation code and a flag saying whether the second operand came from an immediate field. It returns a 32-bit result and a 4-bit condition vector, which a separate branch unit decodes into branch conditions.

The operation code is built as {funct7[5], funct7[1], funct3}. In register mode all five bits matter. In immediate mode only the low three bits choose the operation. The code 10000, which the control path sends for every instruction that is not an arithmetic one, subtracts in register mode. In immediate mode the same code adds, which is what address and upper-immediate arithmetic needs. The flags come from one shared adder, which subtracts for subtraction and both compare operations.

Top module: `int_alu`

## Requirements
- R1: In register mode, funct3 = 0 (code bits 2:0 = 000) adds when code bit 4 is 0 and computes op_a - op_b when bit 4 is 1. Code 10000 is therefore a subtraction.
- R2: In immediate mode (use_imm = 1), code bits 4:3 are ignored. Code 10000 adds, and code 01xxx performs the same operation as 00xxx.
- R3: funct3 = 4 gives op_a XOR op_b, funct3 = 6 gives OR and funct3 = 7 gives AND.
- R4: The flag vector is {V, Z, N, C}. Bit 2 (Z) is set when the adder output is zero. Bit 1 (N) is bit 31 of the adder output. Bit 3 (V) is signed overflow, taken from the operand and adder-output sign bits. The adder subtracts for register subtraction, funct3 = 2 and funct3 = 3, and adds otherwise. For a subtraction, N XOR V equals signed op_a < op_b, and Z equals op_a == op_b.
- R5: Flag bit 0 (C) is the carry out of an addition. For a subtraction it is set exactly when op_a is unsigned-less-than op_b.
- R6: funct3 = 2 (signed) and funct3 = 3 (unsigned) give a set-less-than result of 0 or 1 in bit 0, with bits 31:1 equal to zero.
- R7: funct3 = 1 shifts left logically. funct3 = 5 shifts right. Both use only op_b[4:0] as the shift amount. A right shift is arithmetic when code bit 4 is 1 in register mode, or when op_b[10] is 1 in immediate mode, and logical otherwise.
- R8: In register mode, any code with bit 3 set is reserved and gives a result of zero.
- R9: For operands and codes with no unknown bits, no flag bit is unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register value or immediate) |
| func_code | input | 5 | Operation code {funct7[5], funct7[1], funct3} |
| use_imm | input | 1 | Second operand is an immediate; only code bits 2:0 count |
| result | output | 32 | Operation result |
| flags | output | 4 | Condition flags {V, Z, N, C} |

## Verification
The block has no registers, so the result and all four flags are due in the same cycle the inputs change. The bench drives each input set on the falling clock edge and samples both outputs a short delay later, still well before the next rising edge, so no check depends on the order of processes at an edge. Flags are compared only for the three adder-subtracting operations and for add, since R4 defines them only there. For every other code, the bench checks only that the flags contain no unknown bits.

// File: rtl/int_alu_pkg.sv
// Package: shared widths, flag bit positions and operation selectors for the ALU.
// Assumes a 32-bit datapath; flag positions are fixed because the branch unit decodes them.
package int_alu_pkg;
    localparam int XLEN     = 32;
    localparam int SHAMT_W  = $clog2(XLEN);
    localparam int FLAGS_W  = 4;
    localparam int CODE_W   = 5;

    localparam int FLG_C = 0;
    localparam int FLG_N = 1;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 3;

    typedef enum logic [2:0] {
        F3_ADD  = 3'd0,
        F3_SLL  = 3'd1,
        F3_SLT  = 3'd2,
        F3_SLTU = 3'd3,
        F3_XOR  = 3'd4,
        F3_SR   = 3'd5,
        F3_OR   = 3'd6,
        F3_AND  = 3'd7
    } f3_e;

    typedef enum logic [1:0] {
        LG_XOR = 2'd0,
        LG_OR  = 2'd1,
        LG_AND = 2'd2
    } logic_sel_e;
endpackage

// File: rtl/int_alu_addsub.sv
// Module: shared adder/subtractor. It produces the sum or difference, the carry flag
// (carry out when adding, unsigned borrow when subtracting) and signed overflow.
// Assumes: purely combinational; the caller picks the mode through `sub`.
module int_alu_addsub #(
    parameter int W = int_alu_pkg::XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry_flag,
    output logic         ovf
);
    logic [W:0]   wide;
    logic [W-1:0] b_eff;

    // Purpose: form the W+1 bit sum, with b inverted plus one for subtraction.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
    end

    // Purpose: carry is inverted on subtract so it reads as an unsigned borrow.
    always_comb begin
        carry_flag = sub ? ~wide[W] : wide[W];
        ovf        = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    // Purpose: check the borrow against an independent unsigned comparison.
    always_comb begin
        if (sub && !$isunknown({a, b})) begin
            assert_sub_borrow_R5: assert (carry_flag == (a < b))
                else $error("R5: borrow flag disagrees with unsigned compare");
        end
    end
endmodule

// File: rtl/int_alu_shift.sv
// Module: barrel shifter for left-logical, right-logical and right-arithmetic shifts.
// Assumes: the shift amount is already cut to SHAMT_W bits by the caller.
module int_alu_shift #(
    parameter int W       = int_alu_pkg::XLEN,
    parameter int SHAMT_W = $clog2(W)
) (
    input  logic [W-1:0]       a,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               left,
    input  logic               arith,
    output logic [W-1:0]       out
);
    logic fill;
    logic [W-1:0] stage [SHAMT_W+1];
    logic [W-1:0] a_rev;
    logic [W-1:0] r_rev;

    // Purpose: reverse the operand for left shifts so a single right shifter serves both.
    always_comb begin
        for (int i = 0; i < W; i++) a_rev[i] = a[W-1-i];
        fill     = arith & ~left & a[W-1];
        stage[0] = left ? a_rev : a;
    end

    // Purpose: one log-depth stage per shift-amount bit.
    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
        localparam int D = 1 << s;
        always_comb begin
            stage[s+1] = shamt[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
        end
    end

    // Purpose: undo the reversal on the output for left shifts.
    always_comb begin
        for (int i = 0; i < W; i++) r_rev[i] = stage[SHAMT_W][W-1-i];
        out = left ? r_rev : stage[SHAMT_W];
    end

    // Purpose: a right shift by zero must pass the operand unchanged.
    always_comb begin
        if (!left && shamt == '0 && !$isunknown(a)) begin
            assert_zero_shift_R7: assert (out == a)
                else $error("R7: zero-amount shift changed the operand");
        end
    end
endmodule

// File: rtl/int_alu_logic.sv
// Module: bitwise logic unit (XOR, OR, AND).
// Assumes: selector values come from int_alu_pkg::logic_sel_e; the unused value gives zero.
module int_alu_logic #(
    parameter int W = int_alu_pkg::XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  int_alu_pkg::logic_sel_e sel,
    output logic [W-1:0] out
);
    import int_alu_pkg::*;

    // Purpose: select one bitwise function.
    always_comb begin
        case (sel)
            LG_XOR:  out = a ^ b;
            LG_OR:   out = a | b;
            LG_AND:  out = a & b;
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
// Module: top of the combinational integer ALU. It decodes the 5-bit code
// {funct7[5], funct7[1], funct3}, drives the shared adder, shifter and logic unit,
// and packs the flags as {V, Z, N, C}.
// Assumes: operand muxing is done upstream; flags always come from the shared adder.
module int_alu #(
    parameter int W           = int_alu_pkg::XLEN,
    parameter int IMM_SRA_BIT = 10
) (
    input  logic [W-1:0]                     op_a,
    input  logic [W-1:0]                     op_b,
    input  logic [int_alu_pkg::CODE_W-1:0]   func_code,
    input  logic                             use_imm,
    output logic [W-1:0]                     result,
    output logic [int_alu_pkg::FLAGS_W-1:0]  flags
);
    import int_alu_pkg::*;

    localparam int SW = $clog2(W);

    f3_e        f3;
    logic       alt_bit;
    logic       reserved;
    logic       do_sub;
    logic       sra;
    logic       sh_left;
    logic_sel_e lsel;
    logic [W-1:0] sum;
    logic [W-1:0] sh_out;
    logic [W-1:0] lg_out;
    logic         cflag;
    logic         vflag;

    // Purpose: decode the code into unit controls; immediate mode drops bits 4:3.
    always_comb begin
        f3       = f3_e'(func_code[2:0]);
        alt_bit  = func_code[4] & ~use_imm;
        reserved = func_code[3] & ~use_imm;
        do_sub   = (f3 == F3_SLT) || (f3 == F3_SLTU) || ((f3 == F3_ADD) && alt_bit);
        sra      = use_imm ? op_b[IMM_SRA_BIT] : func_code[4];
        sh_left  = (f3 == F3_SLL);
        case (f3)
            F3_OR:   lsel = LG_OR;
            F3_AND:  lsel = LG_AND;
            default: lsel = LG_XOR;
        endcase
    end

    int_alu_addsub #(.W(W)) u_addsub (
        .a          (op_a),
        .b          (op_b),
        .sub        (do_sub),
        .sum        (sum),
        .carry_flag (cflag),
        .ovf        (vflag)
    );

    int_alu_shift #(.W(W), .SHAMT_W(SW)) u_shift (
        .a     (op_a),
        .shamt (op_b[SW-1:0]),
        .left  (sh_left),
        .arith (sra),
        .out   (sh_out)
    );

    int_alu_logic #(.W(W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (lsel),
        .out (lg_out)
    );

    // Purpose: pack the condition flags from the shared adder.
    always_comb begin
        flags        = '0;
        flags[FLG_C] = cflag;
        flags[FLG_N] = sum[W-1];
        flags[FLG_Z] = (sum == '0);
        flags[FLG_V] = vflag;
    end

    // Purpose: choose the result; set-less-than uses N^V and the borrow.
    always_comb begin
        if (reserved) begin
            result = '0;
        end else begin
            case (f3)
                F3_ADD:  result = sum;
                F3_SLT:  result = {{(W-1){1'b0}}, flags[FLG_N] ^ flags[FLG_V]};
                F3_SLTU: result = {{(W-1){1'b0}}, flags[FLG_C]};
                F3_SLL,
                F3_SR:   result = sh_out;
                default: result = lg_out;
            endcase
        end
    end

    // Purpose: guard the flag contract and the result-shaping rules.
    always_comb begin
        if (!$isunknown({op_a, op_b, func_code, use_imm})) begin
            assert_flags_known_R9: assert (!$isunknown(flags))
                else $error("R9: unknown flag bit");
            if (do_sub) begin
                assert_sub_eq_R4: assert (flags[FLG_Z] == (op_a == op_b))
                    else $error("R4: zero flag differs from equality");
                assert_sub_lt_R4: assert ((flags[FLG_N] ^ flags[FLG_V]) == ($signed(op_a) < $signed(op_b)))
                    else $error("R4: N^V differs from signed less-than");
            end
            if (reserved) begin
                assert_reserved_zero_R8: assert (result == '0)
                    else $error("R8: reserved code gave nonzero result");
            end
            if (!reserved && (f3 == F3_SLT || f3 == F3_SLTU)) begin
                assert_slt_ext_R6: assert (result[W-1:1] == '0)
                    else $error("R6: set-less-than upper bits nonzero");
            end
        end
    end
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [4:0]  func_code = '0;
    logic        use_imm = 1'b0;
    logic [31:0] result;
    logic [3:0]  flags;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    int_alu dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .func_code (func_code),
        .use_imm   (use_imm),
        .result    (result),
        .flags     (flags)
    );

    function automatic logic [31:0] exp_result(logic [31:0] a, logic [31:0] b, logic [4:0] c, logic im);
        logic [2:0] f = c[2:0];
        logic [4:0] sh = b[4:0];
        if (!im && c[3]) return 32'h0;
        case (f)
            3'd0: return (!im && c[4]) ? a - b : a + b;
            3'd1: return a << sh;
            3'd2: return {31'h0, $signed(a) < $signed(b)};
            3'd3: return {31'h0, a < b};
            3'd4: return a ^ b;
            3'd5: return ((im ? b[10] : c[4]) ? $unsigned($signed(a) >>> sh) : a >> sh);
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    // Flags defined only for add, sub, slt, sltu (non-reserved).
    function automatic bit flags_defined(logic [4:0] c, logic im);
        if (!im && c[3]) return 1'b0;
        return (c[2:0] == 3'd0) || (c[2:0] == 3'd2) || (c[2:0] == 3'd3);
    endfunction

    function automatic logic [3:0] exp_flags(logic [31:0] a, logic [31:0] b, logic [4:0] c, logic im);
        bit s = (c[2:0] != 3'd0) || (!im && c[4]);
        logic [32:0] w;
        logic [31:0] r;
        logic cf, vf;
        if (s) begin
            r  = a - b;
            cf = (a < b);
            vf = (a[31] != b[31]) && (r[31] != a[31]);
        end else begin
            w  = {1'b0, a} + {1'b0, b};
            r  = w[31:0];
            cf = w[32];
            vf = (a[31] == b[31]) && (r[31] != a[31]);
        end
        return {vf, (r == 32'h0), r[31], cf};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (a=%h b=%h code=%b imm=%b)",
                     req, act, exp, op_a, op_b, func_code, use_imm);
        end
    endtask

    // Drive on falling edge, sample 2 ns later (combinational block, due same cycle).
    task automatic run(logic [31:0] a, logic [31:0] b, logic [4:0] c, logic im, string req);
        logic [31:0] er;
        logic [3:0]  ef;
        @(negedge clk);
        op_a = a; op_b = b; func_code = c; use_imm = im;
        #2;
        er = exp_result(a, b, c, im);
        check(result === er, req, result, er);
        if (flags_defined(c, im)) begin
            ef = exp_flags(a, b, c, im);
            check(flags === ef, {req, "/R4/R5 flags"}, {28'h0, flags}, {28'h0, ef});
        end
        check(!$isunknown(flags), "R9 flags known", {28'h0, flags}, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        logic [4:0]  rc;
        logic        ri;
        void'($urandom(32'd1234));
        // reset-state: all-zero inputs add to zero with Z set
        @(negedge clk); #2;
        check(result === 32'h0 && flags === 4'b0100, "R4 idle", {28'h0, flags}, 32'h4);
        // R1 add / sub
        run(32'd5, 32'd3, 5'b00000, 1'b0, "R1 add");
        run(32'd5, 32'd3, 5'b10000, 1'b0, "R1 sub");
        run(32'd0, 32'd0, 5'b10000, 1'b0, "R4 equal zero");
        run(32'd0, 32'd1, 5'b10000, 1'b0, "R5 borrow");
        run(32'h8000_0000, 32'd1, 5'b10000, 1'b0, "R4 sub overflow");
        run(32'h7fff_ffff, 32'd1, 5'b00000, 1'b0, "R4 add overflow");
        run(32'hffff_ffff, 32'd1, 5'b00000, 1'b0, "R5 carry out");
        run(32'hffff_ffff, 32'd1, 5'b10000, 1'b0, "R4 signed lt");
        // R2 immediate folding
        run(32'd100, 32'd28, 5'b10000, 1'b1, "R2 imm add");
        run(32'hdead_0000, 32'h0000_beef, 5'b01110, 1'b1, "R2 imm or");
        run(32'hffff_fff0, 32'h10, 5'b11000, 1'b1, "R2 imm add high bits");
        // R3 logic
        run(32'hf0f0_1234, 32'h0ff0_4321, 5'b00100, 1'b0, "R3 xor");
        run(32'hf0f0_1234, 32'h0ff0_4321, 5'b00110, 1'b0, "R3 or");
        run(32'hf0f0_1234, 32'h0ff0_4321, 5'b00111, 1'b0, "R3 and");
        // R6 set-less-than
        run(32'hffff_ffff, 32'd0, 5'b00010, 1'b0, "R6 slt neg");
        run(32'hffff_ffff, 32'd0, 5'b00011, 1'b0, "R6 sltu big");
        run(32'd7, 32'd7, 5'b00010, 1'b1, "R6 slt imm equal");
        // R7 shifts
        run(32'h8000_0001, 32'd31, 5'b00001, 1'b0, "R7 sll 31");
        run(32'h8000_0000, 32'd35, 5'b00101, 1'b0, "R7 srl low bits");
        run(32'h8000_0000, 32'd4, 5'b10101, 1'b0, "R7 sra reg");
        run(32'h8000_0000, 32'h404, 5'b00101, 1'b1, "R7 sra imm b10");
        run(32'h8000_0000, 32'h004, 5'b10101, 1'b1, "R7 srl imm");
        run(32'h1234_5678, 32'd0, 5'b10101, 1'b0, "R7 zero shift");
        // R8 reserved
        run(32'h1234_5678, 32'h1, 5'b01000, 1'b0, "R8 reserved add");
        run(32'hffff_ffff, 32'hffff_ffff, 5'b11111, 1'b0, "R8 reserved and");
        // random
        for (int i = 0; i < 3000; i++) begin
            ra = $urandom; rb = $urandom; rc = 5'($urandom); ri = 1'($urandom);
            if (i % 7 == 0) rb = ra;
            if (i % 11 == 0) ra = {ra[31], 31'h0};
            run(ra, rb, rc, ri, "R1/R2/R3/R6/R7/R8 random");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule